// File: doc/BRIEF.md
# Configurable Sample Averaging Accumulator

This block sits between a stream of 10-bit conversion results and the result FIFO that stores them. It sums a programmable number of consecutive accepted samples and emits one 10-bit average per completed group. Each sample can carry a channel tag, and the tag of the sample that closes a group goes out with the average.

A single averaging unit serves every channel, so all channels get the same factor whether their inputs are single-ended or differential. A 3-bit setting, loaded by a write strobe, gives the factor as a power of two. A setting of zero turns averaging off, and that is the reset value. With averaging off, each sample goes straight to the output. With a factor of N, the output rate is exactly one entry for every N accepted inputs. The output is a register with a valid/ready handshake. When downstream stalls, input samples are held off through a ready signal rather than dropped.

Top module: `sample_avg_acc`

## Requirements
- R1: After reset, out_valid_o is 0, in_ready_o is 1 and averaging is off (setting 0).
- R2: With setting 0, every accepted sample and its tag appear unchanged on out_sample_o and out_tag_o, with out_valid_o high, in the cycle after acceptance.
- R3: A setting k from 1 to 6 selects N = 2^k. The block emits exactly one output per N accepted samples, equal to the sum of those N samples shifted right by k bits, truncated.
- R4: out_valid_o rises in the cycle after the Nth sample of a group is accepted. out_tag_o then carries the tag of that Nth sample, and out_valid_o stays low after any accepted sample that does not complete a group.
- R5: The sum never overflows. 64 samples of value 1023 at setting 6 give an output of 1023.
- R6: A cycle with cfg_wr_i high loads the setting and discards any partial group. in_ready_o is 0 in that cycle, so no sample is taken.
- R7: A written setting of 7 behaves as setting 6, averaging 64 samples.
- R8: While out_valid_o is 1 and out_ready_i is 0, in_ready_o is 0 and out_sample_o and out_tag_o hold their values. A sample held off during this time is taken once out_ready_i returns.
- R9: Cycles with in_valid_i low do not advance the group count and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Load strobe for the averaging setting |
| cfg_shift_i | input | 3 | Averaging setting: 0 off, k gives 2^k samples |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Block can take a sample this cycle |
| in_sample_i | input | 10 | Conversion result |
| in_tag_i | input | 4 | Channel tag of the sample |
| out_valid_o | output | 1 | Averaged result valid |
| out_ready_i | input | 1 | Downstream can take the result |
| out_sample_o | output | 10 | Averaged result |
| out_tag_o | output | 4 | Tag of the group's last sample |

## Verification
The assertions assume that out_ready_i is a plain level with no dependence on in_valid_i. They also assume that a sample offered while in_ready_o is low is simply not taken, so the upstream side must keep it on the bus until it is. The stimulus drives every input on the falling edge. It holds a stalled sample steady until in_ready_o returns, and it only raises cfg_wr_i between samples. Random groups always run with out_ready_i high. A separate directed sequence tests the stall and discard corner cases.

// File: rtl/avg_pkg.sv
package avg_pkg;
  localparam int unsigned AVG_SAMPLE_W = 10;
  localparam int unsigned AVG_TAG_W    = 4;
  localparam int unsigned AVG_MAX_LOG2 = 6;
  localparam int unsigned AVG_CFG_W    = 3;
endpackage

// File: rtl/avg_cfg_reg.sv
module avg_cfg_reg #(
  parameter int unsigned CFG_W    = avg_pkg::AVG_CFG_W,
  parameter int unsigned MAX_LOG2 = avg_pkg::AVG_MAX_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] shift_i,
  output logic [CFG_W-1:0] shift_o
);
  localparam logic [CFG_W-1:0] MaxShift = CFG_W'(MAX_LOG2);

  logic [CFG_W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shift_q <= '0;
    else if (wr_i) shift_q <= (shift_i > MaxShift) ? MaxShift : shift_i;
  end

  assign shift_o = shift_q;

  AST_CFG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_q <= MaxShift); // R7
endmodule

// File: rtl/avg_group_ctr.sv
module avg_group_ctr #(
  parameter int unsigned CFG_W    = avg_pkg::AVG_CFG_W,
  parameter int unsigned MAX_LOG2 = avg_pkg::AVG_MAX_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [CFG_W-1:0] shift_i,
  output logic             last_o
);
  localparam int unsigned CNT_W = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // limit = 2^shift - 1
  assign lim    = ~({CNT_W{1'b1}} << shift_i);
  assign last_o = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/avg_accum.sv
module avg_accum #(
  parameter int unsigned SAMPLE_W = avg_pkg::AVG_SAMPLE_W,
  parameter int unsigned CFG_W    = avg_pkg::AVG_CFG_W,
  parameter int unsigned MAX_LOG2 = avg_pkg::AVG_MAX_LOG2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                add_i,
  input  logic                last_i,
  input  logic [CFG_W-1:0]    shift_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [SAMPLE_W-1:0] avg_o
);
  localparam int unsigned ACC_W = SAMPLE_W + MAX_LOG2;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic [ACC_W:0]   shifted;

  assign sum     = {1'b0, acc_q} + (ACC_W + 1)'(sample_i);
  assign shifted = sum >> shift_i;
  assign avg_o   = shifted[SAMPLE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (add_i) acc_q <= last_i ? '0 : sum[ACC_W-1:0];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i |-> !sum[ACC_W]); // R5
endmodule

// File: rtl/sample_avg_acc.sv
module sample_avg_acc #(
  parameter int unsigned SAMPLE_W = avg_pkg::AVG_SAMPLE_W,
  parameter int unsigned TAG_W    = avg_pkg::AVG_TAG_W,
  parameter int unsigned MAX_LOG2 = avg_pkg::AVG_MAX_LOG2,
  parameter int unsigned CFG_W    = avg_pkg::AVG_CFG_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_wr_i,
  input  logic [CFG_W-1:0]    cfg_shift_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] in_sample_i,
  input  logic [TAG_W-1:0]    in_tag_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [SAMPLE_W-1:0] out_sample_o,
  output logic [TAG_W-1:0]    out_tag_o
);
  logic [CFG_W-1:0]    shift;
  logic                last;
  logic                accept;
  logic [SAMPLE_W-1:0] avg;
  logic                out_valid_q;
  logic [SAMPLE_W-1:0] out_sample_q;
  logic [TAG_W-1:0]    out_tag_q;

  assign in_ready_o = !cfg_wr_i && !(out_valid_q && !out_ready_i);
  assign accept     = in_valid_i && in_ready_o;

  avg_cfg_reg #(.CFG_W(CFG_W), .MAX_LOG2(MAX_LOG2)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .shift_i (cfg_shift_i),
    .shift_o (shift)
  );

  avg_group_ctr #(.CFG_W(CFG_W), .MAX_LOG2(MAX_LOG2)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cfg_wr_i),
    .step_i  (accept),
    .shift_i (shift),
    .last_o  (last)
  );

  avg_accum #(.SAMPLE_W(SAMPLE_W), .CFG_W(CFG_W), .MAX_LOG2(MAX_LOG2)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cfg_wr_i),
    .add_i    (accept),
    .last_i   (last),
    .shift_i  (shift),
    .sample_i (in_sample_i),
    .avg_o    (avg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q  <= 1'b0;
      out_sample_q <= '0;
      out_tag_q    <= '0;
    end else if (accept && last) begin
      out_valid_q  <= 1'b1;
      out_sample_q <= avg;
      out_tag_q    <= in_tag_i;
    end else if (out_ready_i) begin
      out_valid_q  <= 1'b0;
    end
  end

  assign out_valid_o  = out_valid_q;
  assign out_sample_o = out_sample_q;
  assign out_tag_o    = out_tag_q;

  AST_STALL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o); // R8
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_sample_o)
                                       && $stable(out_tag_o))); // R8
  AST_CFG_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |-> !in_ready_o); // R6
  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && shift == '0) |=>
      (out_valid_o && out_sample_o == $past(in_sample_i)
       && out_tag_o == $past(in_tag_i))); // R2
endmodule

// File: tb/sample_avg_acc_bench.sv
module sample_avg_acc_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_shift = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_sample = '0;
  logic [3:0] in_tag = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [9:0] out_sample;
  logic [3:0] out_tag;

  int errors = 0;
  int checks = 0;
  int m_k = 0;
  int m_cnt = 0;
  int m_sum = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_avg_acc u_sample_avg_acc (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cfg_wr_i     (cfg_wr),
    .cfg_shift_i  (cfg_shift),
    .in_valid_i   (in_valid),
    .in_ready_o   (in_ready),
    .in_sample_i  (in_sample),
    .in_tag_i     (in_tag),
    .out_valid_o  (out_valid),
    .out_ready_i  (out_ready),
    .out_sample_o (out_sample),
    .out_tag_o    (out_tag)
  );

  function automatic int eff_shift(input int raw);
    return (raw > 6) ? 6 : raw;
  endfunction

  function automatic int exp_avg(input int sum, input int k);
    return (sum >> k) & 10'h3ff;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int raw);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_shift = 3'(raw);
    in_valid = 1'b1; in_sample = 10'h155;
    #1 chk(in_ready == 1'b0, "R6 in_ready during cfg write", int'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0; in_valid = 1'b0;
    m_k = eff_shift(raw); m_cnt = 0; m_sum = 0;
  endtask

  // drive one sample (out_ready high), check the output one cycle later
  task automatic send(input int s, input int t);
    in_valid = 1'b1; in_sample = 10'(s); in_tag = 4'(t);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    m_sum += s; m_cnt++;
    if (m_cnt == (1 << m_k)) begin
      chk(out_valid == 1'b1, "R4 valid after Nth sample", int'(out_valid), 1);
      chk(int'(out_sample) == exp_avg(m_sum, m_k), "R3 average value",
          int'(out_sample), exp_avg(m_sum, m_k));
      chk(int'(out_tag) == t, "R4 tag of last sample", int'(out_tag), t);
      m_sum = 0; m_cnt = 0;
    end else begin
      chk(out_valid == 1'b0, "R4 no output mid-group", int'(out_valid), 0);
    end
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 idle cycle gives no output", int'(out_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    // R1/R2 default is pass-through, no write yet
    m_k = 0;
    send(10'h3ff, 3);
    send(0, 5);
    send(517, 9);
    chk(out_sample == 10'd517, "R2 pass-through value", int'(out_sample), 517);

    // R9 gaps inside a group
    set_cfg(2);
    send(100, 1); idle(); send(200, 2); idle(); idle(); send(300, 3); send(401, 4);

    // R6 partial group discarded by a write
    set_cfg(1);
    send(900, 7);
    set_cfg(1);
    send(4, 8);
    send(6, 9);
    chk(out_sample == 10'd5, "R6 partial group discarded", int'(out_sample), 5);

    // R5 full-scale 64 samples
    set_cfg(6);
    for (int i = 0; i < 64; i++) send(1023, i % 16);
    chk(out_sample == 10'd1023, "R5 full-scale average", int'(out_sample), 1023);

    // R7 setting 7 acts as 64
    set_cfg(7);
    for (int i = 0; i < 63; i++) send(i * 3, 2);
    chk(out_valid == 1'b0, "R7 no output after 63 samples", int'(out_valid), 0);
    send(500, 11);
    chk(out_valid == 1'b1, "R7 output after 64th sample", int'(out_valid), 1);

    // R3 random groups across all settings
    for (int k = 0; k <= 6; k++) begin
      set_cfg(k);
      for (int i = 0; i < ((k == 6) ? 64 : 3 * (1 << k)); i++) begin
        send(int'($urandom_range(0, 1023)), int'($urandom_range(0, 15)));
        if ($urandom_range(0, 3) == 0) idle();
      end
    end

    // R8 backpressure
    set_cfg(0);
    out_ready = 1'b0;
    send(321, 6);
    in_valid = 1'b1; in_sample = 10'd654; in_tag = 4'd12;
    #1 chk(in_ready == 1'b0, "R8 in_ready low under stall", int'(in_ready), 0);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk(out_valid == 1'b1, "R8 valid held under stall", int'(out_valid), 1);
    chk(out_sample == 10'd321, "R8 data held under stall", int'(out_sample), 321);
    chk(out_tag == 4'd6, "R8 tag held under stall", int'(out_tag), 6);
    out_ready = 1'b1;
    #1 chk(in_ready == 1'b1, "R8 in_ready returns", int'(in_ready), 1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(out_sample == 10'd654, "R8 held-off sample taken", int'(out_sample), 654);
    chk(out_tag == 4'd12, "R8 held-off tag taken", int'(out_tag), 12);
    @(posedge clk); @(negedge clk);
    chk(out_valid == 1'b0, "R8 valid drops after handoff", int'(out_valid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule